// File: doc/BRIEF.md
# Rectangle Raster-Operation Blitter

This block applies one raster operation to a rectangle of 8-bit pixels held in an on-chip pixel RAM. Software loads a command through a small word-addressed register port. The command holds an operation code, a plane mask, a scan-direction word, the destination corner, the width/height pair and the source corner. Writing the source corner launches the command. The engine then visits every pixel of the rectangle. For each pixel it runs a read-modify-write and changes only the bit planes that the plane mask selects.

The walk order can be chosen separately for each axis. This keeps screen-to-screen copies correct when the source and destination rectangles overlap. Software polls a done bit to learn that the command has finished. A solid fill to an arbitrary colour is issued as a set pass followed by a clear pass, each with its own mask. The same register port also gives idle-time access to single pixels, which is how the RAM is loaded and inspected.

Top module: `blit_engine`

## Requirements
- R1: Each coordinate word (destination corner, width/height pair, source corner, pixel position) carries X in bits 15:0 and Y in bits 31:16. The frame is 2^FB_XB pixels wide and 2^FB_YB pixels tall. Pixel (x, y) lives at RAM address {y, x}.
- R2: The command register offsets are: 0 for the operation code (bits 7:0), 1 for the plane mask (bits 7:0), 2 for the direction word, 3 for the destination corner and 4 for the width/height pair. A write to offset 5 sets the source corner and launches the command.
- R3: Operation code 0x00 clears the masked destination bits and 0xFF sets them. Code 0x33 copies the masked source bits into the destination, and 0xCC inverts the masked destination bits. Any other code writes every pixel back unchanged.
- R4: Destination bits outside the plane mask keep their previous value under every operation.
- R5: A read at offset 6 returns the done flag in bit 2, with all other bits zero. The flag is 1 after reset. The command takes k cycles per pixel, where k is 3 for code 0x33 and 2 for every other code. For a w×h command, done reads 0 from the cycle after the launch edge and is set again by the edge w·h·k cycles after the launch edge.
- R6: Rows are walked bottom-to-top when bits 3 and 1 of the direction word are both set. The first source row is then the Y written in the source word, and the first destination row is the destination Y minus one. Otherwise rows are walked top-to-bottom from the written Y values.
- R7: Columns are walked right-to-left when bits 2 and 0 of the direction word are both set. The first source column is then the written source X, and the first destination column is the destination X minus one. Otherwise columns are walked left-to-right.
- R8: A command with zero width or zero height touches no pixel, and done reads 1 on the cycle after the launch edge.
- R9: While a command runs, writes to every offset are ignored. This covers command registers, the launch word, the pixel position and pixel data.
- R10: When idle, a write to offset 6 sets the pixel position, and a write to offset 7 stores bits 7:0 into the addressed pixel. A read at offset 7 returns that pixel, zero-extended, on rd_data in the cycle after the read. Pixel reads while busy, and reads at offsets 0 to 5, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |

## Verification
Every read result is due one cycle after the edge that samples rd_en. A status read taken at edge E therefore shows the done flag as it stood after edge E-1. The bench reference model ticks a remaining-cycle count on every edge, with w·h·k loaded at the launch edge. Each poll is compared against that count as it stood when the read was driven, so the done transition is pinned to the exact cycle. Pixel contents are checked only after done, by reading every pixel one cycle after its read strobe and comparing it with a behavioural model. That model applies each rectangle operation to a snapshot of the frame.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int PIX_W = 8;
  localparam int CRD_W = 16;
  localparam int REG_W = 32;
  localparam int RA_W  = 3;

  localparam logic [RA_W-1:0] RA_OP     = 3'd0;
  localparam logic [RA_W-1:0] RA_MASK   = 3'd1;
  localparam logic [RA_W-1:0] RA_DIR    = 3'd2;
  localparam logic [RA_W-1:0] RA_DST    = 3'd3;
  localparam logic [RA_W-1:0] RA_SIZE   = 3'd4;
  localparam logic [RA_W-1:0] RA_SRC    = 3'd5;
  localparam logic [RA_W-1:0] RA_PIXPOS = 3'd6;
  localparam logic [RA_W-1:0] RA_PIXDAT = 3'd7;

  localparam int STAT_DONE_BIT = 2;

  localparam logic [PIX_W-1:0] OPC_CLEAR  = 8'h00;
  localparam logic [PIX_W-1:0] OPC_COPY   = 8'h33;
  localparam logic [PIX_W-1:0] OPC_INVERT = 8'hCC;
  localparam logic [PIX_W-1:0] OPC_SET    = 8'hFF;

  typedef struct packed {
    logic [PIX_W-1:0] op;
    logic [PIX_W-1:0] mask;
    logic             back_x;
    logic             back_y;
    logic [CRD_W-1:0] sx;
    logic [CRD_W-1:0] sy;
    logic [CRD_W-1:0] dx;
    logic [CRD_W-1:0] dy;
    logic [CRD_W-1:0] w;
    logic [CRD_W-1:0] h;
  } blit_cmd_t;

  typedef enum logic [1:0] {WS_IDLE, WS_RD_SRC, WS_RD_DST, WS_WRITE} walk_state_e;

  function automatic logic [CRD_W-1:0] lo_half(input logic [REG_W-1:0] word);
    return word[CRD_W-1:0];
  endfunction

  function automatic logic [CRD_W-1:0] hi_half(input logic [REG_W-1:0] word);
    return word[REG_W-1:CRD_W];
  endfunction

  function automatic logic op_reads_src(input logic [PIX_W-1:0] op);
    return op == OPC_COPY;
  endfunction

  // Both bits of a pair must be set to reverse that axis
  function automatic logic dir_back_y(input logic [PIX_W-1:0] d);
    return d[3] & d[1];
  endfunction

  function automatic logic dir_back_x(input logic [PIX_W-1:0] d);
    return d[2] & d[0];
  endfunction

  function automatic logic [PIX_W-1:0] rop_merge(input logic [PIX_W-1:0] op,
                                                 input logic [PIX_W-1:0] mask,
                                                 input logic [PIX_W-1:0] src,
                                                 input logic [PIX_W-1:0] dst);
    logic [PIX_W-1:0] f;
    case (op)
      OPC_CLEAR:  f = '0;
      OPC_SET:    f = '1;
      OPC_COPY:   f = src;
      OPC_INVERT: f = ~dst;
      default:    f = dst;
    endcase
    return (dst & ~mask) | (f & mask);
  endfunction
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RA_W-1:0]  wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             busy,
  output blit_cmd_t        cmd,
  output logic             launch,
  output logic [REG_W-1:0] pix_pos,
  output logic             pix_we,
  output logic [PIX_W-1:0] pix_wdata
);
  logic             accept;
  logic [PIX_W-1:0] op_q, mask_q;
  logic             bx_q, by_q;
  logic [REG_W-1:0] dst_q, size_q, pos_q;

  assign accept = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      mask_q <= '0;
      bx_q   <= 1'b0;
      by_q   <= 1'b0;
      dst_q  <= '0;
      size_q <= '0;
      pos_q  <= '0;
    end else if (accept) begin
      case (wr_addr)
        RA_OP:     op_q   <= wr_data[PIX_W-1:0];
        RA_MASK:   mask_q <= wr_data[PIX_W-1:0];
        RA_DIR: begin
          bx_q <= dir_back_x(wr_data[PIX_W-1:0]);
          by_q <= dir_back_y(wr_data[PIX_W-1:0]);
        end
        RA_DST:    dst_q  <= wr_data;
        RA_SIZE:   size_q <= wr_data;
        RA_PIXPOS: pos_q  <= wr_data;
        default: ;
      endcase
    end
  end

  assign launch    = accept && (wr_addr == RA_SRC);
  assign pix_we    = accept && (wr_addr == RA_PIXDAT);
  assign pix_wdata = wr_data[PIX_W-1:0];
  assign pix_pos   = pos_q;

  always_comb begin
    cmd.op     = op_q;
    cmd.mask   = mask_q;
    cmd.back_x = bx_q;
    cmd.back_y = by_q;
    cmd.sx     = lo_half(wr_data);
    cmd.sy     = hi_half(wr_data);
    cmd.dx     = lo_half(dst_q);
    cmd.dy     = hi_half(dst_q);
    cmd.w      = lo_half(size_q);
    cmd.h      = hi_half(size_q);
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import blit_pkg::*;
#(
  parameter int XB = 4,
  parameter int YB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  blit_cmd_t        cmd,
  input  logic [PIX_W-1:0] ram_q,
  output logic             ram_en,
  output logic             ram_we,
  output logic [XB+YB-1:0] ram_addr,
  output logic [PIX_W-1:0] ram_wdata,
  output logic             busy,
  output logic [PIX_W-1:0] act_mask
);
  walk_state_e      st_q;
  logic [PIX_W-1:0] op_q, mask_q, src_px_q;
  logic             bx_q, by_q;
  logic [XB-1:0]    sx_q, dx_q, sx0_q, dx0_q;
  logic [YB-1:0]    sy_q, dy_q;
  logic [CRD_W-1:0] col_q, row_q, wlast_q, hlast_q;
  logic             zero_sz, col_end, row_end;
  logic [XB-1:0]    dx_first;
  logic [YB-1:0]    dy_first;
  walk_state_e      first_st, loop_st;
  logic             unused_hi;

  assign zero_sz  = (cmd.w == '0) || (cmd.h == '0);
  assign col_end  = (col_q == wlast_q);
  assign row_end  = (row_q == hlast_q);
  assign dx_first = cmd.back_x ? cmd.dx[XB-1:0] - XB'(1) : cmd.dx[XB-1:0];
  assign dy_first = cmd.back_y ? cmd.dy[YB-1:0] - YB'(1) : cmd.dy[YB-1:0];
  assign first_st = op_reads_src(cmd.op) ? WS_RD_SRC : WS_RD_DST;
  assign loop_st  = op_reads_src(op_q) ? WS_RD_SRC : WS_RD_DST;
  assign unused_hi = ^{cmd.sx[CRD_W-1:XB], cmd.dx[CRD_W-1:XB],
                       cmd.sy[CRD_W-1:YB], cmd.dy[CRD_W-1:YB]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= WS_IDLE;
      op_q     <= '0;
      mask_q   <= '0;
      src_px_q <= '0;
      bx_q     <= 1'b0;
      by_q     <= 1'b0;
      sx_q     <= '0;
      dx_q     <= '0;
      sx0_q    <= '0;
      dx0_q    <= '0;
      sy_q     <= '0;
      dy_q     <= '0;
      col_q    <= '0;
      row_q    <= '0;
      wlast_q  <= '0;
      hlast_q  <= '0;
    end else begin
      case (st_q)
        WS_IDLE: if (launch && !zero_sz) begin
          st_q    <= first_st;
          op_q    <= cmd.op;
          mask_q  <= cmd.mask;
          bx_q    <= cmd.back_x;
          by_q    <= cmd.back_y;
          sx_q    <= cmd.sx[XB-1:0];
          sx0_q   <= cmd.sx[XB-1:0];
          dx_q    <= dx_first;
          dx0_q   <= dx_first;
          sy_q    <= cmd.sy[YB-1:0];
          dy_q    <= dy_first;
          col_q   <= '0;
          row_q   <= '0;
          wlast_q <= cmd.w - CRD_W'(1);
          hlast_q <= cmd.h - CRD_W'(1);
        end
        WS_RD_SRC: st_q <= WS_RD_DST;
        WS_RD_DST: begin
          st_q <= WS_WRITE;
          if (op_reads_src(op_q)) src_px_q <= ram_q;
        end
        WS_WRITE: begin
          if (col_end) begin
            col_q <= '0;
            sx_q  <= sx0_q;
            dx_q  <= dx0_q;
            if (row_end) begin
              st_q <= WS_IDLE;
            end else begin
              st_q  <= loop_st;
              row_q <= row_q + CRD_W'(1);
              sy_q  <= by_q ? sy_q - YB'(1) : sy_q + YB'(1);
              dy_q  <= by_q ? dy_q - YB'(1) : dy_q + YB'(1);
            end
          end else begin
            st_q  <= loop_st;
            col_q <= col_q + CRD_W'(1);
            sx_q  <= bx_q ? sx_q - XB'(1) : sx_q + XB'(1);
            dx_q  <= bx_q ? dx_q - XB'(1) : dx_q + XB'(1);
          end
        end
        default: st_q <= WS_IDLE;
      endcase
    end
  end

  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = {dy_q, dx_q};
    ram_wdata = rop_merge(op_q, mask_q, src_px_q, ram_q);
    case (st_q)
      WS_RD_SRC: begin
        ram_en   = 1'b1;
        ram_addr = {sy_q, sx_q};
      end
      WS_RD_DST: ram_en = 1'b1;
      WS_WRITE: begin
        ram_en = 1'b1;
        ram_we = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy     = (st_q != WS_IDLE);
  assign act_mask = mask_q;
endmodule

// File: rtl/blit_pixram.sv
module blit_pixram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q         <= mem[addr];
    end
  end
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int FB_XB = 4,
  parameter int FB_YB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RA_W-1:0]  wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [RA_W-1:0]  rd_addr,
  output logic [REG_W-1:0] rd_data
);
  localparam int AW = FB_XB + FB_YB;

  blit_cmd_t        cmd;
  logic             launch, busy, done;
  logic [REG_W-1:0] pix_pos;
  logic             pix_we;
  logic [PIX_W-1:0] pix_wdata;
  logic             eng_en, eng_we;
  logic [AW-1:0]    eng_addr, host_addr, ram_addr;
  logic [PIX_W-1:0] eng_wdata, ram_wdata, ram_q, act_mask;
  logic             host_rd, ram_en, ram_we;
  logic             rd_pix_q, stat_q;
  logic             unused_pos;

  blit_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (busy),
    .cmd      (cmd),
    .launch   (launch),
    .pix_pos  (pix_pos),
    .pix_we   (pix_we),
    .pix_wdata(pix_wdata)
  );

  blit_walker #(.XB(FB_XB), .YB(FB_YB)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .cmd      (cmd),
    .ram_q    (ram_q),
    .ram_en   (eng_en),
    .ram_we   (eng_we),
    .ram_addr (eng_addr),
    .ram_wdata(eng_wdata),
    .busy     (busy),
    .act_mask (act_mask)
  );

  assign done       = !busy;
  assign host_rd    = rd_en && (rd_addr == RA_PIXDAT) && !busy;
  assign host_addr  = {pix_pos[CRD_W+FB_YB-1:CRD_W], pix_pos[FB_XB-1:0]};
  assign unused_pos = ^{pix_pos[REG_W-1:CRD_W+FB_YB], pix_pos[CRD_W-1:FB_XB]};

  // Engine owns the RAM port while busy; host pixel traffic otherwise
  assign ram_en    = busy ? eng_en    : (pix_we || host_rd);
  assign ram_we    = busy ? eng_we    : pix_we;
  assign ram_addr  = busy ? eng_addr  : host_addr;
  assign ram_wdata = busy ? eng_wdata : pix_wdata;

  blit_pixram #(.AW(AW), .DW(PIX_W)) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .q    (ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pix_q <= 1'b0;
      stat_q   <= 1'b0;
    end else if (rd_en) begin
      rd_pix_q <= host_rd;
      stat_q   <= (rd_addr == RA_PIXPOS) && done;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_pix_q) rd_data[PIX_W-1:0] = ram_q;
    else          rd_data[STAT_DONE_BIT] = stat_q;
  end
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk
  import blit_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             launch,
  input logic [CRD_W-1:0] cmd_w,
  input logic [CRD_W-1:0] cmd_h,
  input logic [PIX_W-1:0] cmd_op,
  input logic             done,
  input logic             eng_we,
  input logic [PIX_W-1:0] eng_wdata,
  input logic [PIX_W-1:0] ram_q,
  input logic [PIX_W-1:0] act_mask,
  input logic             wr_en,
  input logic [RA_W-1:0]  wr_addr,
  input logic             rd_en,
  input logic [RA_W-1:0]  rd_addr,
  input logic             rd_stat
);
  AST_LAUNCH_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && cmd_w != '0 && cmd_h != '0) |=> !done); // R5

  AST_ZERO_SIZE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && (cmd_w == '0 || cmd_h == '0)) |=> done); // R8

  AST_UNMASKED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> (((eng_wdata ^ ram_q) & ~act_mask) == '0)); // R4

  AST_OP_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && wr_en && wr_addr == RA_OP) |=> $stable(cmd_op)); // R9

  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !launch); // R9

  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == RA_PIXPOS) |=> (rd_stat == $past(done))); // R5
endmodule

bind blit_engine blit_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .launch   (launch),
  .cmd_w    (cmd.w),
  .cmd_h    (cmd.h),
  .cmd_op   (cmd.op),
  .done     (done),
  .eng_we   (eng_we),
  .eng_wdata(eng_wdata),
  .ram_q    (ram_q),
  .act_mask (act_mask),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_stat  (rd_data[2])
);

// File: tb/tb_blit_engine.sv
`timescale 1ns/1ps
module tb_blit_engine;
  localparam int XB = 4;
  localparam int YB = 4;
  localparam int FW = 1 << XB;
  localparam int FH = 1 << YB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;

  always #2.5 clk = ~clk;

  blit_engine #(.FB_XB(XB), .FB_YB(YB)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int model [FW*FH];
  int remain = 0;
  int pend_cycles = 0;
  bit pend = 0;
  bit ended = 0;

  // Reference timing: cycles left until done, ticked on every edge
  always @(posedge clk) begin
    if (pend) begin
      remain = pend_cycles;
      pend = 0;
    end else if (remain > 0) begin
      remain = remain - 1;
    end
  end

  function automatic logic [31:0] pk(input int x, input int y);
    return {y[15:0], x[15:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic go(input logic [31:0] src, input int cyc);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd5; wr_data = src;
    pend_cycles = cyc; pend = 1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic poll(input string req);
    bit fin = 0;
    bit exp;
    while (!fin) begin
      @(negedge clk);
      exp = (remain == 0);
      rd_en = 1'b1; rd_addr = 3'd6;
      @(posedge clk); #1;
      rd_en = 1'b0;
      #1;
      chk(req, rd_data, exp ? 32'h4 : 32'h0);
      fin = exp;
    end
  endtask

  task automatic read_pix(input int x, input int y, output logic [31:0] v);
    wr(6, pk(x, y));
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'd7;
    @(posedge clk); #1;
    rd_en = 1'b0;
    #1;
    v = rd_data;
  endtask

  task automatic scan(input string req);
    logic [31:0] v;
    for (int y = 0; y < FH; y++)
      for (int x = 0; x < FW; x++) begin
        read_pix(x, y, v);
        chk(req, v, 32'(model[y*FW+x]));
      end
  endtask

  task automatic m_rop(input int op, input int mask, input int sx, input int sy,
                       input int dx, input int dy, input int w, input int h);
    int snap [FW*FH];
    int d, f, s;
    snap = model;
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++) begin
        d = snap[(dy+j)*FW + dx+i];
        s = snap[(sy+j)*FW + sx+i];
        case (op)
          'h00: f = 0;
          'hff: f = 'hff;
          'h33: f = s;
          'hcc: f = ~d & 'hff;
          default: f = d;
        endcase
        model[(dy+j)*FW + dx+i] = ((d & ~mask) | (f & mask)) & 'hff;
      end
  endtask

  task automatic blit(input string req, input int op, input int mask, input int sx, input int sy,
                      input int dx, input int dy, input int w, input int h);
    int dir = 0;
    int wsx = sx, wsy = sy, wdx = dx, wdy = dy;
    if (sy < dy) begin dir |= 'ha; wsy = sy + h - 1; wdy = dy + h; end
    if (sx < dx) begin dir |= 'h5; wsx = sx + w - 1; wdx = dx + w; end
    wr(0, op); wr(1, mask); wr(2, dir);
    wr(3, pk(wdx, wdy)); wr(4, pk(w, h));
    go(pk(wsx, wsy), w * h * ((op == 'h33) ? 3 : 2));
    m_rop(op, mask, sx, sy, dx, dy, w, h);
    poll(req);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R5 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    poll("R5 reset status");

    // R10 R1: load the frame through the pixel window
    for (int y = 0; y < FH; y++)
      for (int x = 0; x < FW; x++) begin
        model[y*FW+x] = (x*29 + y*71 + 3) & 'hff;
        wr(6, pk(x, y));
        wr(7, 32'(model[y*FW+x]));
      end
    scan("R10 R1 pixel load");

    blit("R2 R3 R4 R5 set", 'hff, 'h0f, 2, 3, 2, 3, 4, 2);
    blit("R3 R4 clear", 'h00, 'hf0, 5, 1, 5, 1, 6, 3);
    blit("R3 invert", 'hcc, 'h7f, 0, 10, 0, 10, 7, 4);
    scan("R3 R4 set/clear/invert");

    blit("R3 R4 copy", 'h33, 'h3c, 8, 8, 1, 1, 5, 4);
    blit("R3 unknown code", 'h5a, 'hff, 3, 3, 3, 3, 4, 4);
    scan("R3 copy and unknown code");

    blit("R6 R7 overlap down-right", 'h33, 'hff, 2, 2, 4, 5, 6, 5);
    scan("R6 R7 overlap down-right");
    blit("R7 overlap right", 'h33, 'hff, 1, 9, 3, 9, 8, 3);
    scan("R7 overlap right");
    blit("R6 R7 overlap up-left", 'h33, 'hff, 5, 6, 3, 4, 6, 5);
    scan("R6 R7 forward overlap");

    // Two-pass fill to colour 0x25 on seven planes
    blit("R4 fill set pass", 'hff, 'h25, 9, 0, 9, 0, 5, 6);
    blit("R4 fill clear pass", 'h00, 'h5a, 9, 0, 9, 0, 5, 6);
    scan("R4 two-pass fill");

    blit("R8 zero width", 'hff, 'hff, 0, 0, 0, 0, 0, 3);
    blit("R8 zero height", 'h00, 'hff, 0, 0, 0, 0, 4, 0);
    scan("R8 zero size untouched");

    // R9: busy-time writes must not disturb the running command
    wr(0, 'hcc); wr(1, 'hff); wr(2, 0);
    wr(3, pk(0, 0)); wr(4, pk(8, 8));
    go(pk(0, 0), 128);
    m_rop('hcc, 'hff, 0, 0, 0, 0, 8, 8);
    wr(0, 'h00); wr(1, 'h00); wr(7, 'h00); wr(5, pk(4, 4)); wr(4, pk(1, 1));
    poll("R9 busy command");
    wr(3, pk(9, 9)); wr(4, pk(3, 3));
    go(pk(9, 9), 18);
    m_rop('hcc, 'hff, 9, 9, 9, 9, 3, 3);
    poll("R9 kept registers");
    scan("R9 ignored writes");

    finish_run();
  end
endmodule